// File: doc/BRIEF.md
# Staged Logarithmic Barrel Shifter

This block moves an 8-bit word by any distance from 0 to 7 positions in a single pass, with no iteration. It can shift left or right with zero fill, shift right while replicating the sign bit, or rotate in either direction. The result is captured in an output register, so it appears one clock after the operands are presented.

Inside, three fixed-distance stages are chained. The first moves by 4 positions, the second by 2 and the third by 1. Each stage is enabled by its own bit of the shift amount. Every bit of every stage goes through a four-input selector that chooses one of three things: the bit passing straight through, the bit arriving from the left neighbour at the stage's distance, or the bit arriving from the right neighbour at that distance. Bit positions at the ends of the word, which have no neighbour at that distance, get a two-input catch selector. It supplies either the bit wrapped around from the far end of the word or the fill value.

Top module: `log_barrel_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` is loaded with zero.
- R2: `dout` reflects the operands sampled at the previous rising clock edge. A change on the inputs leaves `dout` unchanged until the next edge.
- R3: With `amt` = 0, `dout` equals `din` for every `op` and `dir` value.
- R4: `op` = 2'b00 (logical) with `dir` = 0 (left) gives `din` shifted toward the MSB by `amt`, and the vacated low bits are zero.
- R5: `op` = 2'b00 with `dir` = 1 (right) gives `din` shifted toward the LSB by `amt`, and the vacated high bits are zero.
- R6: `op` = 2'b01 (arithmetic) with `dir` = 1 gives a right shift in which every vacated high bit equals `din[7]`.
- R7: `op` = 2'b01 with `dir` = 0 gives the same result as a logical left shift.
- R8: `op` = 2'b10 (rotate) with `dir` = 0 gives a left rotation: bits leaving the MSB end re-enter at the LSB end, so no bit is lost.
- R9: `op` = 2'b10 with `dir` = 1 gives a right rotation: bits leaving the LSB end re-enter at the MSB end.
- R10: `op` = 2'b11 is reserved and gives the logical result in both directions.
- R11: `amt` bit 2 selects a distance of 4, bit 1 a distance of 2 and bit 0 a distance of 1. Every amount from 0 to 7 gives the full composed distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Word to be shifted |
| amt | input | 3 | Shift distance, 0 to 7 |
| dir | input | 1 | 0 = toward MSB (left), 1 = toward LSB (right) |
| op | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved (logical) |
| dout | output | 8 | Registered shifted word |

## Verification
Some properties can be judged from the operands of the previous cycle alone, and the assertions check these on every cycle. They are: the reset clears the register; a zero amount returns the word unchanged; a rotation keeps the count of one bits; an arithmetic right shift keeps the sign bit; and a logical fill leaves a zero at the end the word moved away from. The exact bit placement of each operation cannot be shown by those local properties. Only the bench's scenarios show it. They compare every data value, amount and direction for all four operation codes against a reference built from the language's shift operators, and they also show the one-cycle latency.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [1:0] {
    OP_LOGIC  = 2'b00,
    OP_ARITH  = 2'b01,
    OP_ROTATE = 2'b10,
    OP_RSVD   = 2'b11
  } bsh_op_e;
endpackage

// File: rtl/bsh_sel4.sv
// Four-input bit selector: sel 00->a, 01->b, 10->c, 11->d
module bsh_sel4 (
  input  logic [1:0] sel,
  input  logic       a,
  input  logic       b,
  input  logic       c,
  input  logic       d,
  output logic       y
);
  always_comb begin
    unique case (sel)
      2'b00:   y = a;
      2'b01:   y = b;
      2'b10:   y = c;
      default: y = d;
    endcase
  end
endmodule

// File: rtl/bsh_catch.sv
// Two-input catch selector: sel 1 -> a (wrapped bit), sel 0 -> b (fill)
module bsh_catch (
  input  logic sel,
  input  logic a,
  input  logic b,
  output logic y
);
  assign y = sel ? a : b;
endmodule

// File: rtl/bsh_stage.sv
// One fixed-distance stage of the cascade.
module bsh_stage #(
  parameter int W    = 8,
  parameter int DIST = 4
) (
  input  logic [W-1:0] in_w,
  input  logic         en,
  input  logic         dir,
  input  logic         rot,
  input  logic         ari,
  output logic [W-1:0] out_w
);
  // Right-shift fill when not rotating: sign bit in arithmetic mode, else zero
  logic fill_r;
  assign fill_r = ari & in_w[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_lo;  // source for a move toward MSB
    logic from_hi;  // source for a move toward LSB

    if (i >= DIST) begin : g_lo_in
      assign from_lo = in_w[i-DIST];
    end else begin : g_lo_catch
      bsh_catch u_catch_l (
        .sel (rot),
        .a   (in_w[W-DIST+i]),
        .b   (1'b0),
        .y   (from_lo)
      );
    end

    if (i + DIST < W) begin : g_hi_in
      assign from_hi = in_w[i+DIST];
    end else begin : g_hi_catch
      bsh_catch u_catch_r (
        .sel (rot),
        .a   (in_w[i+DIST-W]),
        .b   (fill_r),
        .y   (from_hi)
      );
    end

    bsh_sel4 u_sel (
      .sel ({en, dir}),
      .a   (in_w[i]),
      .b   (in_w[i]),
      .c   (from_lo),
      .d   (from_hi),
      .y   (out_w[i])
    );
  end
endmodule

// File: rtl/log_barrel_shifter.sv
module log_barrel_shifter #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          dir,
  input  logic [1:0]    op,
  output logic [W-1:0]  dout
);
  import bsh_pkg::*;

  logic rot, ari;
  assign rot = (bsh_op_e'(op) == OP_ROTATE);
  assign ari = (bsh_op_e'(op) == OP_ARITH) & dir;

  // chain[0] is the input, chain[SW] the shifted result
  logic [W-1:0] chain [SW+1];
  assign chain[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int BIT = SW - 1 - k;
    bsh_stage #(.W(W), .DIST(1 << BIT)) u_stage (
      .in_w  (chain[k]),
      .en    (amt[BIT]),
      .dir   (dir),
      .rot   (rot),
      .ari   (ari),
      .out_w (chain[k+1])
    );
  end

  logic vld;
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      dout <= chain[SW];
      vld  <= 1'b1;
    end
  end

  // R1: reset leaves the register cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dout == '0);

  // R3: zero distance is the identity
  p_zero_amt_r3: assert property (@(posedge clk) disable iff (rst)
    vld && $past(amt) == '0 |-> dout == $past(din));

  // R8/R9: rotation loses no bit
  p_rot_pop_r8: assert property (@(posedge clk) disable iff (rst)
    vld && $past(op) == 2'b10 |-> $countones(dout) == $countones($past(din)));

  // R6: arithmetic right keeps the sign
  p_ari_sign_r6: assert property (@(posedge clk) disable iff (rst)
    vld && $past(op) == 2'b01 && $past(dir) |-> dout[W-1] == $past(din[W-1]));

  // R4/R7: non-rotating left shift brings a zero into bit 0
  p_left_fill_r4: assert property (@(posedge clk) disable iff (rst)
    vld && !$past(dir) && $past(op) != 2'b10 && $past(amt) != '0 |-> dout[0] == 1'b0);

  // R5/R10: logical right shift brings a zero into the MSB
  p_right_fill_r5: assert property (@(posedge clk) disable iff (rst)
    vld && $past(dir) && ($past(op) == 2'b00 || $past(op) == 2'b11) && $past(amt) != '0
    |-> dout[W-1] == 1'b0);
endmodule

// File: tb/tb_log_barrel_shifter.sv
module tb_log_barrel_shifter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] din;
  logic [2:0] amt;
  logic       dir;
  logic [1:0] op;
  logic [7:0] dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_barrel_shifter dut (
    .clk(clk), .rst(rst), .din(din), .amt(amt), .dir(dir), .op(op), .dout(dout)
  );

  function automatic logic [7:0] ref_model(input logic [7:0] d, input logic [2:0] a,
                                           input logic r, input logic [1:0] o);
    logic [15:0] dbl;
    logic [7:0]  res;
    dbl = {d, d};
    if (o == 2'b10) begin
      if (r) begin dbl = dbl >> a; res = dbl[7:0]; end
      else   begin dbl = dbl << a; res = dbl[15:8]; end
    end else if (r) begin
      if (o == 2'b01) res = 8'($signed(d) >>> a);
      else            res = d >> a;
    end else begin
      res = d << a;
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: din=%h amt=%0d dir=%0d op=%0d got=%h exp=%h",
               tag, din, amt, dir, op, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [2:0] a,
                       input logic r, input logic [1:0] o, input string tag);
    @(negedge clk);
    din = d; amt = a; dir = r; op = o;
    @(negedge clk);
    check(tag, dout, ref_model(d, a, r, o));
  endtask

  task automatic t_reset;  // R1
    rst = 1'b1; din = 8'hA5; amt = 3'd1; dir = 1'b0; op = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 reset", dout, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_latency;  // R2
    apply(8'h81, 3'd1, 1'b0, 2'b10, "R2 first");
    @(negedge clk);
    din = 8'h0F; amt = 3'd4; dir = 1'b0; op = 2'b00;
    #1 check("R2 hold", dout, 8'h03);
    @(negedge clk);
    check("R2 update", dout, 8'hF0);
  endtask

  task automatic t_identity;  // R3
    for (int o = 0; o < 4; o++)
      for (int r = 0; r < 2; r++) begin
        apply(8'hC3, 3'd0, r[0], o[1:0], "R3 zero amount");
        check("R3 value", dout, 8'hC3);
      end
  endtask

  task automatic t_sweep(input logic [1:0] o, input logic r, input string tag);
    for (int d = 0; d < 256; d++)
      for (int a = 0; a < 8; a++)
        apply(d[7:0], a[2:0], r, o, tag);
  endtask

  task automatic t_directed;  // R6, R8, R9, R11 hand-worked values
    apply(8'h90, 3'd4, 1'b1, 2'b01, "R6 sign fill");
    check("R6 value", dout, 8'hF9);
    apply(8'h96, 3'd3, 1'b0, 2'b10, "R8 rotl");
    check("R8 value", dout, 8'hB4);
    apply(8'h96, 3'd3, 1'b1, 2'b10, "R9 rotr");
    check("R9 value", dout, 8'hD2);
    apply(8'h01, 3'd7, 1'b0, 2'b00, "R11 full distance");
    check("R11 value", dout, 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_identity();
    t_directed();
    t_sweep(2'b00, 1'b0, "R4 logical left");
    t_sweep(2'b00, 1'b1, "R5 logical right");
    t_sweep(2'b01, 1'b1, "R6 arithmetic right");
    t_sweep(2'b01, 1'b0, "R7 arithmetic left");
    t_sweep(2'b10, 1'b0, "R8 rotate left");
    t_sweep(2'b10, 1'b1, "R9 rotate right");
    t_sweep(2'b11, 1'b0, "R10 reserved left");
    t_sweep(2'b11, 1'b1, "R10 reserved right");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule